// File: doc/BRIEF.md
# Cache Size ID Read Unit

This block answers read requests for a per-cache size identification system register. Each request carries the five-field register encoding, the current exception level, two feature-present flags, the hypervisor control bits (EL2 enable, trap-general-exceptions, and two ID-group trap bits), and the current cache selection: a level field and an instruction/data selector bit.

The block first checks whether the encoding belongs to this register. It then applies a privilege-dependent trap decision with a fixed priority. The result is one of four outcomes:
- a 64-bit value, whose low 24 bits give the number of sets minus one for the selected cache;
- an undefined-instruction outcome;
- a trap, reported with a target level and the 6-bit syndrome class;
- a not-claimed status, when the encoding belongs to another register.

The set counts, the set of implemented levels and the unified-cache mask are parameters.

Requests are accepted with a valid/ready handshake. The response is registered and appears exactly one cycle after acceptance.

Top module: `cache_geom_rd`

## Requirements
- R1: A request is claimed only when op0=2'b11, op1=3'b001, CRn=4'b0000, CRm=4'b0000 and op2=3'b010. Any other encoding responds with status 3 (not claimed), and its data is zero. Status codes are: 0 ok, 1 undefined, 2 trap, 3 not claimed.
- R2: When the extended cache-index feature flag is clear, a claimed access responds with status 1 at every exception level (EL encoded 0..3).
- R3: On every response, data bits [63:24] are zero.
- R4: A returned set-count field may hold any 24-bit value, including values one less than a non-power-of-two and 24'hFFFFFF.
- R5: The table entry is picked by index level*2+selector. For a level marked unified, both selector values return the same entry, the one at selector 0.
- R6: At EL0 with the ID-trap feature flag set, the response is a trap (status 2). Its target is 2 when EL2 is enabled and TGE=1, and 1 otherwise. At EL0 with that flag clear, the status is 1.
- R7: At EL1 with EL2 enabled, TID2=1 or TID4=1 gives a trap to target 2. Otherwise the value is returned with status 0. When EL2 is disabled, both bits are ignored.
- R8: At EL2 and EL3 the value is always returned with status 0, whatever the trap bits and feature flag for ID traps.
- R9: A selected level that is not implemented returns status 0 with all-zero data.
- R10: The response is valid exactly one cycle after each accepted request, and never otherwise. The syndrome class is 6'h18 on a trap and 0 otherwise. The target is 0 unless the status is trap. Data is zero unless the status is ok.
- R11: While reset is asserted, req_ready_o and rsp_valid_o are 0. req_ready_o is 1 from the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_op0_i | input | 2 | Encoding field op0 |
| req_op1_i | input | 3 | Encoding field op1 |
| req_crn_i | input | 4 | Encoding field CRn |
| req_crm_i | input | 4 | Encoding field CRm |
| req_op2_i | input | 3 | Encoding field op2 |
| cur_el_i | input | 2 | Current exception level, 0..3 |
| feat_ext_idx_i | input | 1 | Extended cache-index feature present |
| feat_id_trap_i | input | 1 | ID-space trap feature present |
| el2_en_i | input | 1 | EL2 enabled in the current state |
| hcr_tge_i | input | 1 | Trap general exceptions to EL2 |
| hcr_tid2_i | input | 1 | Trap ID group 2 |
| hcr_tid4_i | input | 1 | Trap ID group 4 |
| sel_level_i | input | 3 | Selected cache level field (level minus one) |
| sel_instr_i | input | 1 | Selector: 1 instruction, 0 data or unified |
| rsp_valid_o | output | 1 | Response valid |
| rsp_status_o | output | 2 | 0 ok, 1 undefined, 2 trap, 3 not claimed |
| rsp_target_el_o | output | 2 | Trap target level |
| rsp_ec_o | output | 6 | Syndrome class |
| rsp_data_o | output | 64 | Register value |

## Verification
The trap decision and the table lookup are computed in the same cycle for every request. A trapping or undefined outcome must therefore suppress the value that the lookup has already produced. The bench provokes this by sending trapping and undefined requests that select implemented levels with non-zero entries, and then checks that the data is zero and that the target and class match the outcome. Back-to-back requests, where a response leaves in the same cycle that the next request is accepted, are mixed with idle cycles. A queue-based model then judges each cycle for response presence and content.

// File: rtl/cache_geom_pkg.sv
package cache_geom_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_UNDEF   = 2'd1,
    ST_TRAP    = 2'd2,
    ST_NOMATCH = 2'd3
  } rd_status_e;

  localparam logic [5:0] EC_SYSREG = 6'h18;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysreg_enc_t;

  typedef struct packed {
    rd_status_e status;
    logic [1:0] target_el;
    logic [5:0] ec;
  } access_res_t;
endpackage

// File: rtl/cgr_decode.sv
module cgr_decode
  import cache_geom_pkg::*;
#(
  parameter sysreg_enc_t MATCH_ENC = '{op0: 2'b11, op1: 3'b001, crn: 4'b0000, crm: 4'b0000, op2: 3'b010}
) (
  input  sysreg_enc_t enc_i,
  output logic        hit_o
);
  always_comb begin
    hit_o = (enc_i.op0 == MATCH_ENC.op0) && (enc_i.op1 == MATCH_ENC.op1) &&
            (enc_i.crn == MATCH_ENC.crn) && (enc_i.crm == MATCH_ENC.crm) &&
            (enc_i.op2 == MATCH_ENC.op2);
  end
endmodule

// File: rtl/cgr_access_ctl.sv
module cgr_access_ctl
  import cache_geom_pkg::*;
(
  input  logic        hit_i,
  input  logic        feat_ext_idx_i,
  input  logic        feat_id_trap_i,
  input  logic [1:0]  cur_el_i,
  input  logic        el2_en_i,
  input  logic        hcr_tge_i,
  input  logic        hcr_tid2_i,
  input  logic        hcr_tid4_i,
  output access_res_t res_o
);
  always_comb begin
    res_o = '{status: ST_OK, target_el: 2'd0, ec: 6'd0};
    if (!hit_i) begin
      res_o.status = ST_NOMATCH;
    end else if (!feat_ext_idx_i) begin
      res_o.status = ST_UNDEF;
    end else begin
      unique case (cur_el_i)
        2'd0: begin
          if (feat_id_trap_i) begin
            res_o.status    = ST_TRAP;
            res_o.ec        = EC_SYSREG;
            res_o.target_el = (el2_en_i && hcr_tge_i) ? 2'd2 : 2'd1;
          end else begin
            res_o.status = ST_UNDEF;
          end
        end
        2'd1: begin
          // group-2 bit has priority; both route to the same target
          if (el2_en_i && (hcr_tid2_i || hcr_tid4_i)) begin
            res_o.status    = ST_TRAP;
            res_o.ec        = EC_SYSREG;
            res_o.target_el = 2'd2;
          end
        end
        default: res_o.status = ST_OK;
      endcase
    end
  end
endmodule

// File: rtl/cgr_table.sv
module cgr_table #(
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned SETS_W  = 24,
  parameter int unsigned NUM_LVL = 1 << LVL_W,
  parameter int unsigned NUM_ENT = 2 * NUM_LVL,
  parameter logic [NUM_ENT*SETS_W-1:0] SETS = '0,
  parameter logic [NUM_LVL-1:0] LVL_IMPL = '0,
  parameter logic [NUM_LVL-1:0] LVL_UNIFIED = '0
) (
  input  logic [LVL_W-1:0]  level_i,
  input  logic              instr_i,
  output logic [SETS_W-1:0] sets_o,
  output logic              impl_o
);
  localparam int unsigned IDX_W = LVL_W + 1;

  logic [SETS_W-1:0] ent [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    assign ent[g] = SETS[g*SETS_W +: SETS_W];
  end

  logic [IDX_W-1:0] idx;
  always_comb begin
    idx    = {level_i, instr_i & ~LVL_UNIFIED[level_i]};
    sets_o = ent[idx];
    impl_o = LVL_IMPL[level_i];
  end
endmodule

// File: rtl/cache_geom_rd.sv
module cache_geom_rd
  import cache_geom_pkg::*;
#(
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned SETS_W  = 24,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned NUM_LVL = 1 << LVL_W,
  parameter int unsigned NUM_ENT = 2 * NUM_LVL,
  parameter logic [NUM_ENT*SETS_W-1:0] SETS = {
    {(NUM_ENT-6){24'd0}}, 24'd5, 24'hFFFFFF, 24'd9, 24'd1499, 24'd127, 24'd255},
  parameter logic [NUM_LVL-1:0] LVL_IMPL    = 8'b0000_0111,
  parameter logic [NUM_LVL-1:0] LVL_UNIFIED = 8'b0000_0110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op0_i,
  input  logic [2:0]        req_op1_i,
  input  logic [3:0]        req_crn_i,
  input  logic [3:0]        req_crm_i,
  input  logic [2:0]        req_op2_i,
  input  logic [1:0]        cur_el_i,
  input  logic              feat_ext_idx_i,
  input  logic              feat_id_trap_i,
  input  logic              el2_en_i,
  input  logic              hcr_tge_i,
  input  logic              hcr_tid2_i,
  input  logic              hcr_tid4_i,
  input  logic [LVL_W-1:0]  sel_level_i,
  input  logic              sel_instr_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [1:0]        rsp_target_el_o,
  output logic [5:0]        rsp_ec_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int unsigned PAD_W = DATA_W - SETS_W;

  sysreg_enc_t       enc;
  logic              hit;
  access_res_t       res;
  logic [SETS_W-1:0] sets;
  logic              impl;
  logic [DATA_W-1:0] data_d;
  logic              ready_q;
  logic              accept;

  assign enc = '{op0: req_op0_i, op1: req_op1_i, crn: req_crn_i, crm: req_crm_i, op2: req_op2_i};

  cgr_decode u_dec (
    .enc_i (enc),
    .hit_o (hit)
  );

  cgr_access_ctl u_acc (
    .hit_i          (hit),
    .feat_ext_idx_i (feat_ext_idx_i),
    .feat_id_trap_i (feat_id_trap_i),
    .cur_el_i       (cur_el_i),
    .el2_en_i       (el2_en_i),
    .hcr_tge_i      (hcr_tge_i),
    .hcr_tid2_i     (hcr_tid2_i),
    .hcr_tid4_i     (hcr_tid4_i),
    .res_o          (res)
  );

  cgr_table #(
    .LVL_W       (LVL_W),
    .SETS_W      (SETS_W),
    .NUM_LVL     (NUM_LVL),
    .NUM_ENT     (NUM_ENT),
    .SETS        (SETS),
    .LVL_IMPL    (LVL_IMPL),
    .LVL_UNIFIED (LVL_UNIFIED)
  ) u_tbl (
    .level_i (sel_level_i),
    .instr_i (sel_instr_i),
    .sets_o  (sets),
    .impl_o  (impl)
  );

  // non-implemented level: zero data, ok status
  always_comb begin
    data_d = '0;
    if (res.status == ST_OK && impl) data_d = {{PAD_W{1'b0}}, sets};
  end

  assign req_ready_o = ready_q;
  assign accept      = req_valid_i && ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q         <= 1'b0;
      rsp_valid_o     <= 1'b0;
      rsp_status_o    <= 2'd0;
      rsp_target_el_o <= 2'd0;
      rsp_ec_o        <= 6'd0;
      rsp_data_o      <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_status_o    <= res.status;
        rsp_target_el_o <= res.target_el;
        rsp_ec_o        <= res.ec;
        rsp_data_o      <= data_d;
      end
    end
  end
endmodule

// File: rtl/cgr_checker.sv
module cgr_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [1:0]  req_op0_i,
  input logic [2:0]  req_op1_i,
  input logic [3:0]  req_crn_i,
  input logic [3:0]  req_crm_i,
  input logic [2:0]  req_op2_i,
  input logic [1:0]  cur_el_i,
  input logic        feat_ext_idx_i,
  input logic        feat_id_trap_i,
  input logic        el2_en_i,
  input logic        hcr_tge_i,
  input logic        rsp_valid_o,
  input logic [1:0]  rsp_status_o,
  input logic [1:0]  rsp_target_el_o,
  input logic [5:0]  rsp_ec_o,
  input logic [63:0] rsp_data_o
);
  logic acc, claim;
  assign acc   = req_valid_i && req_ready_o;
  assign claim = req_op0_i == 2'b11 && req_op1_i == 3'b001 && req_crn_i == 4'd0 &&
                 req_crm_i == 4'd0 && req_op2_i == 3'b010;

  a_r10_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_data_o[63:24] == 40'd0);
  a_r10_data_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != 2'd0) |-> rsp_data_o == 64'd0);
  a_r10_ec_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'd2) |-> rsp_ec_o == 6'h18);
  a_r1_nomatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !claim) |=> rsp_status_o == 2'd3);
  a_r2_feat_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && claim && !feat_ext_idx_i) |=> rsp_status_o == 2'd1);
  a_r8_high_el_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && claim && feat_ext_idx_i && cur_el_i[1]) |=> rsp_status_o == 2'd0);
  a_r6_el0_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && claim && feat_ext_idx_i && cur_el_i == 2'd0 && feat_id_trap_i) |=>
      (rsp_status_o == 2'd2 &&
       rsp_target_el_o == (($past(el2_en_i) && $past(hcr_tge_i)) ? 2'd2 : 2'd1)));
endmodule

bind cache_geom_rd cgr_checker u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_op0_i       (req_op0_i),
  .req_op1_i       (req_op1_i),
  .req_crn_i       (req_crn_i),
  .req_crm_i       (req_crm_i),
  .req_op2_i       (req_op2_i),
  .cur_el_i        (cur_el_i),
  .feat_ext_idx_i  (feat_ext_idx_i),
  .feat_id_trap_i  (feat_id_trap_i),
  .el2_en_i        (el2_en_i),
  .hcr_tge_i       (hcr_tge_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_status_o    (rsp_status_o),
  .rsp_target_el_o (rsp_target_el_o),
  .rsp_ec_o        (rsp_ec_o),
  .rsp_data_o      (rsp_data_o)
);

// File: tb/sim_cache_geom_rd.sv
module sim_cache_geom_rd;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_op0_i = '0;
  logic [2:0]  req_op1_i = '0;
  logic [3:0]  req_crn_i = '0;
  logic [3:0]  req_crm_i = '0;
  logic [2:0]  req_op2_i = '0;
  logic [1:0]  cur_el_i = '0;
  logic        feat_ext_idx_i = 1'b0, feat_id_trap_i = 1'b0;
  logic        el2_en_i = 1'b0, hcr_tge_i = 1'b0, hcr_tid2_i = 1'b0, hcr_tid4_i = 1'b0;
  logic [2:0]  sel_level_i = '0;
  logic        sel_instr_i = 1'b0;
  logic        rsp_valid_o;
  logic [1:0]  rsp_status_o, rsp_target_el_o;
  logic [5:0]  rsp_ec_o;
  logic [63:0] rsp_data_o;

  cache_geom_rd u0 (.*);

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic [1:0] op0; logic [2:0] op1; logic [3:0] crn; logic [3:0] crm; logic [2:0] op2;
    logic [1:0] el; logic fx; logic ft; logic e2; logic tge; logic t2; logic t4;
    logic [2:0] lvl; logic ins;
  } req_t;

  typedef struct {
    int st; int tg; int ec; logic [63:0] data; string stag; string dtag;
  } exp_t;

  exp_t q[$];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic req_t base();
    req_t r = '0;
    r.op0 = 2'b11; r.op1 = 3'b001; r.op2 = 3'b010;
    r.el = 2'd2; r.fx = 1'b1;
    return r;
  endfunction

  // configured cache geometry, written from the requirement text
  function automatic void sets_of(input logic [2:0] lvl, input logic ins,
                                  output logic [63:0] v, output string tag);
    case (lvl)
      3'd0: begin v = ins ? 64'd127 : 64'd255; tag = "R5"; end
      3'd1: begin v = 64'd1499; tag = "R4"; end   // unified, 1500 sets
      3'd2: begin v = 64'hFFFFFF; tag = "R5"; end // unified, field all ones
      default: begin v = 64'd0; tag = "R9"; end
    endcase
  endfunction

  function automatic exp_t model(req_t r);
    exp_t e;
    bit hit = r.op0 == 2'b11 && r.op1 == 3'b001 && r.crn == 0 && r.crm == 0 && r.op2 == 3'b010;
    e.st = 0; e.tg = 0; e.ec = 0; e.data = 0; e.dtag = "R10";
    if (!hit) begin e.st = 3; e.stag = "R1"; end
    else if (!r.fx) begin e.st = 1; e.stag = "R2"; end
    else if (r.el == 0) begin
      e.stag = "R6";
      if (r.ft) begin e.st = 2; e.ec = 24; e.tg = (r.e2 && r.tge) ? 2 : 1; end
      else e.st = 1;
    end else if (r.el == 1) begin
      e.stag = "R7";
      if (r.e2 && (r.t2 || r.t4)) begin e.st = 2; e.ec = 24; e.tg = 2; end
    end else e.stag = "R8";
    if (e.st == 0) sets_of(r.lvl, r.ins, e.data, e.dtag);
    return e;
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    if (q.size() > 0) begin
      exp_t e = q.pop_front();
      chk("R10", "rsp_valid", {63'd0, rsp_valid_o}, 64'd1);
      chk(e.stag, "status", {62'd0, rsp_status_o}, 64'(e.st));
      chk(e.stag, "target", {62'd0, rsp_target_el_o}, 64'(e.tg));
      chk("R10", "ec", {58'd0, rsp_ec_o}, 64'(e.ec));
      chk(e.dtag, "data", rsp_data_o, e.data);
      chk("R3", "upper bits", {24'd0, rsp_data_o[63:24]}, 64'd0);
    end else begin
      chk("R10", "rsp_valid idle", {63'd0, rsp_valid_o}, 64'd0);
    end
  endtask

  task automatic send(bit v, req_t r);
    req_valid_i = v;
    {req_op0_i, req_op1_i, req_crn_i, req_crm_i, req_op2_i} = {r.op0, r.op1, r.crn, r.crm, r.op2};
    cur_el_i = r.el; feat_ext_idx_i = r.fx; feat_id_trap_i = r.ft;
    el2_en_i = r.e2; hcr_tge_i = r.tge; hcr_tid2_i = r.t2; hcr_tid4_i = r.t4;
    sel_level_i = r.lvl; sel_instr_i = r.ins;
    if (v) q.push_back(model(r));
    tick();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    req_t r;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R11 reset state
    chk("R11", "ready in reset", {63'd0, req_ready_o}, 64'd0);
    chk("R11", "rsp_valid in reset", {63'd0, rsp_valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R11", "ready after reset", {63'd0, req_ready_o}, 64'd1);

    // R5 R4 R9: every level and selector at EL2
    for (int l = 0; l < 8; l++)
      for (int i = 0; i < 2; i++) begin
        r = base(); r.lvl = 3'(l); r.ins = 1'(i);
        send(1'b1, r);
      end

    // R8: trap bits ignored at EL2/EL3
    for (int el = 2; el < 4; el++) begin
      r = base(); r.el = 2'(el); r.e2 = 1; r.tge = 1; r.t2 = 1; r.t4 = 1; r.ft = 1; r.lvl = 3'd1;
      send(1'b1, r);
    end

    // R7: EL1 cases, trap with valid selection checks data suppression
    for (int k = 0; k < 8; k++) begin
      r = base(); r.el = 2'd1; r.e2 = 1'(k >> 2); r.t2 = 1'(k >> 1); r.t4 = 1'(k); r.lvl = 3'd0;
      send(1'b1, r);
      send(1'b0, r);
    end

    // R6: EL0 routing and undefined without the trap feature
    for (int k = 0; k < 8; k++) begin
      r = base(); r.el = 2'd0; r.ft = 1'(k >> 2); r.e2 = 1'(k >> 1); r.tge = 1'(k); r.lvl = 3'd2;
      send(1'b1, r);
    end

    // R2: feature clear at each level
    for (int el = 0; el < 4; el++) begin
      r = base(); r.el = 2'(el); r.fx = 0; r.ft = 1; r.lvl = 3'd0;
      send(1'b1, r);
    end

    // R1: flip each encoding field
    for (int f = 0; f < 5; f++) begin
      r = base();
      case (f)
        0: r.op0 = 2'b10;
        1: r.op1 = 3'b000;
        2: r.crn = 4'd1;
        3: r.crm = 4'd1;
        default: r.op2 = 3'b001;
      endcase
      send(1'b1, r);
    end

    // mixed stream with idle gaps
    for (int n = 0; n < 600; n++) begin
      r = base();
      if ($urandom_range(0, 7) == 0) r.op2 = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) r.crm = 4'($urandom_range(0, 15));
      r.el = 2'($urandom_range(0, 3));
      r.fx = ($urandom_range(0, 7) != 0);
      r.ft = 1'($urandom_range(0, 1)); r.e2 = 1'($urandom_range(0, 1));
      r.tge = 1'($urandom_range(0, 1)); r.t2 = ($urandom_range(0, 3) == 0);
      r.t4 = ($urandom_range(0, 3) == 0);
      r.lvl = 3'($urandom_range(0, 7)); r.ins = 1'($urandom_range(0, 1));
      send($urandom_range(0, 3) != 0, r);
    end

    send(1'b0, base());
    finish_run();
  end
endmodule